// File: doc/BRIEF.md
# Parallel Configuration Streaming Controller

The block streams a configuration image, read from a byte-wide memory, to a target device. It sends the image over an 8-bit data bus and generates its own data clock. The data byte changes as the data clock falls, so the target can latch it on the rising edge.

Start-up is a handshake on one shared open-drain enable line. After reset the controller pulls that line low for a selectable hold-off. It then releases the line and waits until the line reads high. The line reads high only once every other agent has let go of it. Only then does streaming begin.

After the last byte, the controller waits one data-clock period and samples the target's done input. If the target has not signalled done, the controller sets an error flag, briefly pulls the enable line low and restarts the image from address zero. If the target pulls the enable line low while streaming or after completion, the controller treats this as a restart request.

Top module: `cfg_stream_ctrl`

## Requirements
- R1: While reset is held, the outputs take these values: `stage` = 0, `oe_drive_low` = 1, `cfg_clk` = 0, `busy` = 1, `cfg_err` = 0, `mem_addr` = 0. The `stage` encoding is 0 hold-off, 1 wait-for-line, 2 streaming, 3 done check, 4 done, 5 error retry.
- R2: After reset is released, `oe_drive_low` stays high for exactly 2·CYC_PER_MS clock cycles when `hold_long` = 0, and for 100·CYC_PER_MS cycles when `hold_long` = 1.
- R3: After the hold-off, the block stays in stage 1 while `oe_in` reads low, with no `cfg_clk` edges. It starts streaming once `oe_in` reads high.
- R4: One stream presents IMG_BYTES bytes in address order from 0. Byte k equals `mem_data` read at `mem_addr` = k, and `mem_addr` never exceeds IMG_BYTES.
- R5: `cfg_data` changes only together with a falling edge of `cfg_clk`. It holds steady while `cfg_clk` is high, and each byte is on the bus before the rising edge that carries it.
- R6: One `cfg_clk` period after the final falling edge, `done_n` is sampled. If it reads low, the block enters stage 4 with `busy` = 0 and `cfg_err` = 0.
- R7: If `done_n` still reads high at that check, the block does the following. It sets `cfg_err` to 1 and enters stage 5, where it drives `oe_drive_low` for 2·HALF_DIV cycles. It then waits for the line and streams again from address 0. A later successful check clears `cfg_err`.
- R8: If `oe_in` reads low during streaming, the next cycle shows stage 1 with `mem_addr` = 0 and `cfg_clk` = 0. The next stream restarts at byte 0.
- R9: If `oe_in` reads low in stage 4, the block returns to stage 1 with `busy` = 1 and streams the whole image again.
- R10: `cfg_clk` toggles only while streaming, and its period is 2·HALF_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| hold_long | input | 1 | Hold-off select: 0 short (2 ms), 1 long (100 ms) |
| mem_addr | output | AW | Image memory read address |
| mem_data | input | 8 | Image memory read data |
| cfg_data | output | 8 | Configuration data bus to the target |
| cfg_clk | output | 1 | Generated configuration data clock |
| oe_drive_low | output | 1 | Pull-down enable for the shared open-drain line |
| oe_in | input | 1 | Sensed level of the shared open-drain line |
| done_n | input | 1 | Target done indication, active low |
| cfg_err | output | 1 | Set when the done check fails |
| busy | output | 1 | Low only once configuration has completed |
| stage | output | 3 | Controller state, encoded as in R1 |

## Verification
The bench builds the block with CYC_PER_MS = 3, IMG_BYTES = 5 and HALF_DIV = 2. This gives a 6-cycle short hold-off and a 300-cycle long hold-off, so both can be measured cycle-exactly in one short run. A five-byte image puts the final-byte boundary, the done check and an abort after the second byte all within tens of cycles. A four-cycle data-clock period leaves two cycles per phase, which is enough to show that data moves only on falling edges.

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl #(
  parameter int CYC_PER_MS = 50000,
  parameter int IMG_BYTES  = 4096,
  parameter int HALF_DIV   = 2,
  localparam int AW = $clog2(IMG_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_long,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic [7:0]    cfg_data,
  output logic          cfg_clk,
  output logic          oe_drive_low,
  input  logic          oe_in,
  input  logic          done_n,
  output logic          cfg_err,
  output logic          busy,
  output logic [2:0]    stage
);

  localparam int CW = $clog2(2 * HALF_DIV + 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] PER_M1  = CW'(2 * HALF_DIV - 1);
  localparam logic [AW-1:0] LAST    = AW'(IMG_BYTES);
  localparam logic [31:0]   SHORT_M1 = 32'(2 * CYC_PER_MS - 1);
  localparam logic [31:0]   LONG_M1  = 32'(100 * CYC_PER_MS - 1);

  typedef enum logic [2:0] {
    S_HOLD = 3'd0, S_WAIT = 3'd1, S_SEND = 3'd2,
    S_CHECK = 3'd3, S_DONE = 3'd4, S_RETRY = 3'd5
  } state_t;

  state_t        st;
  logic [31:0]   hcnt;
  logic [CW-1:0] dcnt;
  logic [AW-1:0] addr;

  wire tick    = (dcnt == HALF_M1);
  wire per_end = (dcnt == PER_M1);

  assign oe_drive_low = (st == S_HOLD) || (st == S_RETRY);
  assign busy         = (st != S_DONE);
  assign stage        = st;
  assign mem_addr     = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HOLD;
      hcnt     <= '0;
      dcnt     <= '0;
      addr     <= '0;
      cfg_clk  <= 1'b0;
      cfg_data <= '0;
      cfg_err  <= 1'b0;
    end else begin
      case (st)
        S_HOLD: begin
          if (hcnt == (hold_long ? LONG_M1 : SHORT_M1)) begin
            st   <= S_WAIT;
            hcnt <= '0;
          end else begin
            hcnt <= hcnt + 32'd1;
          end
        end
        S_WAIT: begin
          dcnt    <= '0;
          cfg_clk <= 1'b0;
          if (oe_in) begin
            st       <= S_SEND;
            cfg_data <= mem_data;
            addr     <= AW'(1);
          end
        end
        S_SEND: begin
          if (!oe_in) begin
            st      <= S_WAIT;
            addr    <= '0;
            dcnt    <= '0;
            cfg_clk <= 1'b0;
          end else if (tick) begin
            dcnt <= '0;
            if (!cfg_clk) begin
              cfg_clk <= 1'b1;
            end else begin
              cfg_clk <= 1'b0;
              if (addr == LAST) begin
                st <= S_CHECK;
              end else begin
                cfg_data <= mem_data;
                addr     <= addr + AW'(1);
              end
            end
          end else begin
            dcnt <= dcnt + CW'(1);
          end
        end
        S_CHECK: begin
          if (!oe_in) begin
            st   <= S_WAIT;
            addr <= '0;
            dcnt <= '0;
          end else if (per_end) begin
            dcnt <= '0;
            addr <= '0;
            if (!done_n) begin
              st      <= S_DONE;
              cfg_err <= 1'b0;
            end else begin
              st      <= S_RETRY;
              cfg_err <= 1'b1;
            end
          end else begin
            dcnt <= dcnt + CW'(1);
          end
        end
        S_RETRY: begin
          if (per_end) begin
            dcnt <= '0;
            st   <= S_WAIT;
          end else begin
            dcnt <= dcnt + CW'(1);
          end
        end
        S_DONE: begin
          if (!oe_in) st <= S_WAIT;
        end
        default: st <= S_HOLD;
      endcase
    end
  end

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data));

  // R10
  clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SEND) |-> !cfg_clk);

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && !oe_in) |=> (st == S_WAIT && addr == '0));

  // R6
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (!$past(done_n) && !cfg_err));

  // R7
  err_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> oe_drive_low);

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= LAST);

endmodule

// File: tb/tb_cfg_stream_ctrl.sv
module tb_cfg_stream_ctrl;
  localparam int CLK_P = 10;
  localparam int CYC   = 3;
  localparam int NB    = 5;
  localparam int HD    = 2;
  localparam int AW    = $clog2(NB + 1);

  logic clk = 0, rst_n = 0, hold_long = 0, ext_low = 0, done_n = 1, pass_mode = 0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data, cfg_data;
  logic cfg_clk, oe_drive_low, cfg_err, busy;
  logic [2:0] stage;
  wire oe_in = ~(oe_drive_low | ext_low);

  int tests = 0, fails = 0, ncap = 0;
  logic [7:0] cap [64];
  longint rise_t [64];

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 37 + 11);
  endfunction
  assign mem_data = pat(int'(mem_addr));

  always #(CLK_P / 2) clk = ~clk;

  cfg_stream_ctrl #(.CYC_PER_MS(CYC), .IMG_BYTES(NB), .HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .hold_long(hold_long), .mem_addr(mem_addr),
    .mem_data(mem_data), .cfg_data(cfg_data), .cfg_clk(cfg_clk),
    .oe_drive_low(oe_drive_low), .oe_in(oe_in), .done_n(done_n),
    .cfg_err(cfg_err), .busy(busy), .stage(stage));

  always @(posedge cfg_clk) begin
    cap[ncap % 64] = cfg_data;
    rise_t[ncap % 64] = $time;
    ncap = ncap + 1;
    if (pass_mode && ncap >= NB) done_n = 1'b0;
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lng);
    rst_n = 0; hold_long = lng; ext_low = 0; done_n = 1; pass_mode = 0;
    repeat (3) @(negedge clk);
    ncap = 0;
    rst_n = 1;
  endtask

  task automatic wait_stage(input int s, input int lim);
    for (int n = 0; n < lim && stage != 3'(s); n++) @(negedge clk);
  endtask

  task automatic wait_caps(input int c, input int lim);
    for (int n = 0; n < lim && ncap < c; n++) @(negedge clk);
  endtask

  task automatic check_bytes(input string req);
    check({req, " count"}, ncap, NB);
    for (int k = 0; k < NB; k++) check(req, cap[k], pat(k));
  endtask

  // {hold_long, pass, expected hold cycles}
  localparam logic [17:0] VEC [3] = '{
    {1'b0, 1'b1, 16'(2 * CYC)},
    {1'b1, 1'b1, 16'(100 * CYC)},
    {1'b0, 1'b0, 16'(2 * CYC)}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int h;
    // R1 reset values
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 stage", stage, 0);
    check("R1 oe", oe_drive_low, 1);
    check("R1 clk", cfg_clk, 0);
    check("R1 busy", busy, 1);
    check("R1 err", cfg_err, 0);
    check("R1 addr", mem_addr, 0);

    foreach (VEC[v]) begin
      do_reset(VEC[v][17]);
      h = 0;
      while (oe_drive_low && h < 1000) begin h++; @(negedge clk); end
      check("R2 hold", h, VEC[v][15:0]);
      pass_mode = VEC[v][16];
      wait_caps(NB, 200);
      check_bytes("R4 R5 bytes");
      check("R10 period", rise_t[1] - rise_t[0], 2 * HD * CLK_P);
      if (VEC[v][16]) begin
        wait_stage(4, 100);
        check("R6 stage", stage, 4);
        check("R6 busy", busy, 0);
        check("R6 err", cfg_err, 0);
      end else begin
        for (int n = 0; n < 100 && !cfg_err; n++) @(negedge clk);
        check("R7 err", cfg_err, 1);
        check("R7 oe pulse", oe_drive_low, 1);
        check("R7 stage", stage, 5);
        h = 0;
        while (oe_drive_low && h < 100) begin h++; @(negedge clk); end
        check("R7 pulse len", h, 2 * HD);
        pass_mode = 1; ncap = 0;
        wait_stage(4, 300);
        check_bytes("R7 restream");
        check("R7 err cleared", cfg_err, 0);
      end
    end

    // R3 external stretch of the line
    do_reset(0);
    ext_low = 1;
    repeat (40) @(negedge clk);
    check("R3 waiting", stage, 1);
    check("R3 no clk", ncap, 0);
    pass_mode = 1;
    ext_low = 0;
    wait_stage(4, 300);
    check_bytes("R3 start");

    // R8 abort mid-stream
    do_reset(0);
    pass_mode = 1;
    wait_caps(2, 200);
    ext_low = 1;
    @(negedge clk);
    check("R8 stage", stage, 1);
    check("R8 addr", mem_addr, 0);
    check("R8 clk", cfg_clk, 0);
    repeat (5) @(negedge clk);
    ncap = 0;
    ext_low = 0;
    wait_stage(4, 300);
    check_bytes("R8 restream");

    // R9 restart request from done
    done_n = 1; ext_low = 1;
    @(negedge clk);
    @(negedge clk);
    check("R9 stage", stage, 1);
    check("R9 busy", busy, 1);
    ncap = 0;
    ext_low = 0;
    wait_stage(4, 300);
    check_bytes("R9 restream");
    check("R9 done", stage, 4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule